// File: doc/BRIEF.md
# I2C Command-Word Transaction Engine

This block is an I2C bus master that carries out a whole transaction from one 64-bit command word. The host sets a go bit, and the engine then runs the complete bus sequence with no further help from the host. The sequence covers START, the address phase, an optional one- or two-byte internal address with a repeated START for reads, 1 to 8 data bytes, and STOP. Transfer size, direction, 7- or 10-bit addressing and the internal-address option all come from fields of that word. Data bytes 5 to 8, and the high byte of a two-byte internal address, sit in a second 64-bit extension word.

When the transaction ends, the engine writes its outcome back into the command word. The go bit clears, the direction position turns into a success flag, and on a failure the low byte carries a bus status code. On a successful read, the received bytes land in the same data lanes that a write would have used. Completion also raises a sticky interrupt. The bus side is open-drain: the block only ever pulls SCL or SDA low. A single-cycle tick input paces the bus, and each bit takes four ticks.

Top module: `i2cCmdEngine`

## Requirements
- R1: Writing the command word with bit 63 (go) at 1 launches a transaction. Bit 63 reads 1 while the transaction runs and returns to 0 once it has finished.
- R2: Bits 58:56 hold the data byte count minus one. For a transfer of N bytes, message byte k (k=0 first) is carried in lane N-1-k. Lanes 0..3 are command bits 31:0 and lanes 4..7 are extension bits 31:0, with lane L occupying bits 8*(L mod 4)+7 : 8*(L mod 4).
- R3: Bits 61:60 select the mode. Bit 61 selects 10-bit addressing and bit 60 adds an internal-address phase. The target address is in bits 49:40. In 7-bit mode the address byte is {addr[6:0], rw}. In 10-bit mode the first byte is {11110, addr[9:8], rw} and the second is addr[7:0]. A 10-bit read first sends the write header and the low byte, then a repeated START and the read header.
- R4: With bit 60 set, the internal address byte in command bits 39:32 is sent after the address. If bit 59 is also set, extension bits 39:32 are sent first as the high byte. A read then issues a repeated START and the read header; a write continues directly with the data bytes.
- R5: On a successful read, received byte k is stored into lane N-1-k, using the same layout as R2.
- R6: On completion, bit 62 reads 1 for success and 0 for failure. A NAK ends the transaction with a STOP, and the failure status goes into bits 7:0: 0x20 for a NAK on the write header or 10-bit low address byte, 0x48 for a NAK on the read header, and 0x30 for a NAK on an internal-address or data byte.
- R7: The engine ACKs every received byte except the last one, which it NAKs.
- R8: Completion sets the interrupt output. The interrupt clears only on a cycle where both clear inputs are 1; a clear with only one bit set leaves it high.
- R9: Writes to the command or extension word are ignored while bit 63 is 1.
- R10: SCL is held low for exactly two ticks and high for two ticks per bit. SDA changes while SCL is high only to form START, repeated START or STOP.
- R11: After reset, both words read 0, the interrupt is low and neither bus line is pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle bus pacing strobe, four per bit |
| cmdWrEn | input | 1 | Write strobe for the command word |
| extWrEn | input | 1 | Write strobe for the extension word |
| wrData | input | 64 | Host write data |
| intClr | input | 2 | Interrupt clear bits; both must be 1 to clear |
| sdaIn | input | 1 | Sensed SDA line level |
| cmdWord | output | 64 | Command word, overwritten with the result |
| extWord | output | 64 | Extension word |
| irq | output | 1 | Sticky completion interrupt |
| sclLow | output | 1 | Pull SCL low when 1 |
| sdaLow | output | 1 | Pull SDA low when 1 |

## Verification
The bench builds the engine with its default field layout and raises tick on every second clock, so one bus bit spans eight clocks and even an eight-byte transfer finishes within a few hundred cycles. At this pacing, every mode can be run against a bench target model: 7- and 10-bit addressing, one- and two-byte internal addresses, reads and writes that spill into the extension word, and NAKs on each phase. The short tick period also makes each SCL low pulse short enough to measure exactly.

// File: rtl/i2cCmdPkg.sv
package i2cCmdPkg;
  localparam int WORD_W   = 64;
  localparam int ADDR_W   = 10;
  localparam int SIZE_W   = 3;
  localparam int GO_BIT   = 63;
  localparam int RW_BIT   = 62;
  localparam int TEN_BIT  = 61;
  localparam int IA_BIT   = 60;
  localparam int EIA_BIT  = 59;
  localparam int SIZE_LSB = 56;
  localparam int ADDR_LSB = 40;
  localparam int IA_LSB   = 32;
  localparam logic [7:0] ST_ADDR_W_NAK = 8'h20;
  localparam logic [7:0] ST_DATA_NAK   = 8'h30;
  localparam logic [7:0] ST_ADDR_R_NAK = 8'h48;

  typedef enum logic [2:0] {
    SRC_HDR_W, SRC_HDR_R, SRC_ADDR_LO, SRC_IA_HI, SRC_IA_LO, SRC_DATA
  } txSrc_e;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_HDR_W, PH_ADDR_LO, PH_IA_HI, PH_IA_LO,
    PH_RSTART, PH_HDR_R, PH_DATA, PH_STOP
  } phase_e;

  typedef struct packed {
    logic              valid;
    logic              isRead;
    logic              tenBit;
    logic              hasIa;
    logic              eia;
    logic [SIZE_W-1:0] size;
  } cfg_t;

  typedef struct packed {
    logic              load;
    txSrc_e            src;
    logic              shift;
    logic              store;
    logic [SIZE_W-1:0] byteNum;
    logic              finish;
    logic              ok;
    logic [7:0]        status;
  } strobe_t;
endpackage

// File: rtl/i2cCmdData.sv
module i2cCmdData
  import i2cCmdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic              extWrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic [1:0]        intClr,
  input  strobe_t           strb,
  input  logic              sdaIn,
  output logic [WORD_W-1:0] cmdWord,
  output logic [WORD_W-1:0] extWord,
  output cfg_t              cfg,
  output logic              txBit,
  output logic              irq
);
  localparam int LANE_BITS = 2 * 32;

  logic [WORD_W-1:0]    cmdQ, extQ;
  logic [7:0]           shReg, txByte;
  logic                 irqQ;
  logic [ADDR_W-1:0]    addr;
  logic [LANE_BITS-1:0] lanes;
  logic [SIZE_W-1:0]    laneIdx;

  assign cfg.valid  = cmdQ[GO_BIT];
  assign cfg.isRead = cmdQ[RW_BIT];
  assign cfg.tenBit = cmdQ[TEN_BIT];
  assign cfg.hasIa  = cmdQ[IA_BIT];
  assign cfg.eia    = cmdQ[EIA_BIT];
  assign cfg.size   = cmdQ[SIZE_LSB +: SIZE_W];
  assign addr       = cmdQ[ADDR_LSB +: ADDR_W];
  assign lanes      = {extQ[31:0], cmdQ[31:0]};
  assign laneIdx    = cfg.size - strb.byteNum;

  always_comb begin
    unique case (strb.src)
      SRC_HDR_W:   txByte = cfg.tenBit ? {5'b11110, addr[9:8], 1'b0} : {addr[6:0], 1'b0};
      SRC_HDR_R:   txByte = cfg.tenBit ? {5'b11110, addr[9:8], 1'b1} : {addr[6:0], 1'b1};
      SRC_ADDR_LO: txByte = addr[7:0];
      SRC_IA_HI:   txByte = extQ[IA_LSB +: 8];
      SRC_IA_LO:   txByte = cmdQ[IA_LSB +: 8];
      default:     txByte = lanes[{laneIdx, 3'b000} +: 8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ  <= '0;
      extQ  <= '0;
      shReg <= '0;
      irqQ  <= 1'b0;
    end else begin
      if (cmdWrEn && !cmdQ[GO_BIT]) cmdQ <= wrData;
      if (extWrEn && !cmdQ[GO_BIT]) extQ <= wrData;
      if (strb.load)       shReg <= txByte;
      else if (strb.shift) shReg <= {shReg[6:0], sdaIn};
      if (strb.store) begin
        if (laneIdx[2]) extQ[{laneIdx[1:0], 3'b000} +: 8] <= shReg;
        else            cmdQ[{laneIdx[1:0], 3'b000} +: 8] <= shReg;
      end
      if (strb.finish) begin
        cmdQ[GO_BIT] <= 1'b0;
        cmdQ[RW_BIT] <= strb.ok;
        if (!strb.ok) cmdQ[7:0] <= strb.status;
      end
      if (strb.finish)            irqQ <= 1'b1;
      else if (intClr == 2'b11)   irqQ <= 1'b0;
    end
  end

  assign cmdWord = cmdQ;
  assign extWord = extQ;
  assign txBit   = shReg[7];
  assign irq     = irqQ;

  assert_busy_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ[GO_BIT] && cmdWrEn && !strb.store && !strb.finish) |=> $stable(cmdQ));
  assert_busy_ext_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ[GO_BIT] && extWrEn && !strb.store) |=> $stable(extQ));
  assert_finish_clears_go_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> !cmdQ[GO_BIT]);
  assert_finish_raises_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> irqQ);
endmodule

// File: rtl/i2cCmdCtrl.sv
module i2cCmdCtrl
  import i2cCmdPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  cfg_t    cfg,
  input  logic    txBit,
  input  logic    sdaIn,
  output strobe_t strb,
  output logic    sclLow,
  output logic    sdaLow
);
  phase_e            phase, firstPh, postAddr, nextPh;
  logic [1:0]        q;
  logic [3:0]        bitCnt;
  logic [SIZE_W-1:0] byteNum;
  logic              failed, sclQ, sdaQ;
  logic [7:0]        failStatus, nakCode;
  logic              bytePhase, isTx, lastByte, ackNak;

  always_comb begin
    bytePhase = phase inside {PH_HDR_W, PH_ADDR_LO, PH_IA_HI, PH_IA_LO, PH_HDR_R, PH_DATA};
    isTx      = !(phase == PH_DATA && cfg.isRead);
    lastByte  = (byteNum == cfg.size);
    ackNak    = isTx && (bitCnt == 4'd8) && sdaIn;
    firstPh   = (cfg.isRead && !cfg.tenBit && !cfg.hasIa) ? PH_HDR_R : PH_HDR_W;
    if (cfg.hasIa) postAddr = cfg.eia ? PH_IA_HI : PH_IA_LO;
    else           postAddr = cfg.isRead ? PH_RSTART : PH_DATA;
    unique case (phase)
      PH_HDR_W:   nextPh = cfg.tenBit ? PH_ADDR_LO : postAddr;
      PH_ADDR_LO: nextPh = postAddr;
      PH_IA_HI:   nextPh = PH_IA_LO;
      PH_IA_LO:   nextPh = cfg.isRead ? PH_RSTART : PH_DATA;
      default:    nextPh = PH_DATA;
    endcase
    if (phase == PH_HDR_W || phase == PH_ADDR_LO) nakCode = ST_ADDR_W_NAK;
    else if (phase == PH_HDR_R)                   nakCode = ST_ADDR_R_NAK;
    else                                          nakCode = ST_DATA_NAK;
  end

  always_comb begin
    strb         = '0;
    strb.byteNum = byteNum;
    strb.ok      = !failed;
    strb.status  = failStatus;
    unique case (phase)
      PH_HDR_W:   strb.src = SRC_HDR_W;
      PH_HDR_R:   strb.src = SRC_HDR_R;
      PH_ADDR_LO: strb.src = SRC_ADDR_LO;
      PH_IA_HI:   strb.src = SRC_IA_HI;
      PH_IA_LO:   strb.src = SRC_IA_LO;
      default:    strb.src = SRC_DATA;
    endcase
    if (tick) begin
      strb.load   = bytePhase && isTx && q == 2'd0 && bitCnt == 4'd0;
      strb.shift  = bytePhase && q == 2'd3 && bitCnt < 4'd8;
      strb.store  = phase == PH_DATA && !isTx && q == 2'd3 && bitCnt == 4'd8;
      strb.finish = phase == PH_STOP && q == 2'd3;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE; q <= '0; bitCnt <= '0; byteNum <= '0;
      failed <= 1'b0; failStatus <= '0; sclQ <= 1'b0; sdaQ <= 1'b0;
    end else if (phase == PH_IDLE) begin
      if (cfg.valid) begin
        phase <= PH_START; q <= '0; bitCnt <= '0; byteNum <= '0;
        failed <= 1'b0; failStatus <= '0;
      end
    end else if (tick) begin
      q <= q + 2'd1;
      if (phase == PH_START || phase == PH_RSTART) begin
        if (q == 2'd0) begin
          if (phase == PH_RSTART) sclQ <= 1'b1;
        end else if (q == 2'd1) sdaQ <= 1'b0;
        else if (q == 2'd2) sclQ <= 1'b0;
        else begin
          sdaQ  <= 1'b1;
          phase <= (phase == PH_START) ? firstPh : PH_HDR_R;
        end
      end else if (phase == PH_STOP) begin
        if (q == 2'd0)      sclQ <= 1'b1;
        else if (q == 2'd1) sdaQ <= 1'b1;
        else if (q == 2'd2) sclQ <= 1'b0;
        else begin
          sdaQ  <= 1'b0;
          phase <= PH_IDLE;
        end
      end else begin
        if (q == 2'd0) sclQ <= 1'b1;
        else if (q == 2'd1) begin
          if (bitCnt < 4'd8) sdaQ <= isTx ? ~txBit : 1'b0;
          else               sdaQ <= isTx ? 1'b0 : !lastByte;
        end else if (q == 2'd2) sclQ <= 1'b0;
        else if (bitCnt != 4'd8) bitCnt <= bitCnt + 4'd1;
        else begin
          bitCnt <= '0;
          if (ackNak) begin
            failed     <= 1'b1;
            failStatus <= nakCode;
            phase      <= PH_STOP;
          end else if (phase == PH_DATA) begin
            if (lastByte) phase <= PH_STOP;
            else          byteNum <= byteNum + 1'b1;
          end else phase <= nextPh;
        end
      end
    end
  end

  assign sclLow = sclQ;
  assign sdaLow = sdaQ;

  assert_sda_edge_scl_high_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaQ) && !$past(sclQ)) |->
      ($past(phase) == PH_START || $past(phase) == PH_RSTART || $past(phase) == PH_STOP));
  assert_idle_lines_free_R11: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> (!sclQ && !sdaQ));
  assert_data_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA) |-> (byteNum <= cfg.size));
endmodule

// File: rtl/i2cCmdEngine.sv
module i2cCmdEngine
  import i2cCmdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              cmdWrEn,
  input  logic              extWrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic [1:0]        intClr,
  input  logic              sdaIn,
  output logic [WORD_W-1:0] cmdWord,
  output logic [WORD_W-1:0] extWord,
  output logic              irq,
  output logic              sclLow,
  output logic              sdaLow
);
  cfg_t    cfg;
  strobe_t strb;
  logic    txBit;

  i2cCmdData i_data (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .extWrEn(extWrEn), .wrData(wrData),
    .intClr(intClr), .strb(strb), .sdaIn(sdaIn), .cmdWord(cmdWord), .extWord(extWord),
    .cfg(cfg), .txBit(txBit), .irq(irq)
  );

  i2cCmdCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .cfg(cfg), .txBit(txBit), .sdaIn(sdaIn),
    .strb(strb), .sclLow(sclLow), .sdaLow(sdaLow)
  );
endmodule

// File: tb/test_i2cCmdEngine.sv
module test_i2cCmdEngine;
  logic        clk = 1'b0, rstN = 1'b0, tick = 1'b0;
  logic        cmdWrEn = 1'b0, extWrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic [1:0]  intClr = '0;
  logic [63:0] cmdWord, extWord;
  logic        irq, sclLow, sdaLow;
  logic        slvLow = 1'b0;
  logic        sdaBus;

  int nChecks = 0, nFail = 0;
  int logArr[32]; int logN = 0;
  int expArr[32]; int expN = 0;
  logic [7:0] rdBuf[8]; int rdIdx = 0;
  logic [7:0] mAcks; int ackN = 0;
  int nakAt = -1; int sByteCnt = 0;
  int lowRun = 0, pulses = 0, badPulses = 0;

  assign sdaBus = !(sdaLow || slvLow);

  always #5 clk = ~clk;

  i2cCmdEngine i_i2cCmdEngine (
    .clk(clk), .rstN(rstN), .tick(tick), .cmdWrEn(cmdWrEn), .extWrEn(extWrEn),
    .wrData(wrData), .intClr(intClr), .sdaIn(sdaBus), .cmdWord(cmdWord),
    .extWord(extWord), .irq(irq), .sclLow(sclLow), .sdaLow(sdaLow)
  );

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  // SCL low pulse width monitor
  initial forever begin
    @(negedge clk);
    if (sclLow) lowRun++;
    else begin
      if (lowRun != 0) begin
        pulses++;
        if (lowRun != 4) badPulses++;
      end
      lowRun = 0;
    end
  end

  // Target model: logs every byte and bus condition, answers reads
  initial begin
    logic pScl, pSda, scl, sda, goTx, mAckd;
    int mode, sBit;
    logic [7:0] sh;
    pScl = 1; pSda = 1; goTx = 0; mAckd = 0; mode = 0; sBit = 0; sh = 0;
    forever begin
      @(negedge clk);
      scl = !sclLow; sda = sdaBus;
      if (scl && pScl && pSda && !sda) begin
        if (logN < 32) logArr[logN] = 'h100; logN++;
        mode = 1; sBit = 0; goTx = 0; slvLow = 0;
      end else if (scl && pScl && !pSda && sda) begin
        if (logN < 32) logArr[logN] = 'h200; logN++;
        mode = 0; slvLow = 0;
      end else if (!pScl && scl) begin
        if (mode == 1 && sBit < 8) sh = {sh[6:0], sda};
        if (mode == 2 && sBit == 8) begin
          mAckd = !sda;
          if (ackN < 8) mAcks[ackN] = !sda; ackN++;
        end
        if (mode != 0) sBit++;
      end else if (pScl && !scl) begin
        if (mode == 1) begin
          if (sBit == 8) begin
            if (logN < 32) logArr[logN] = int'(sh); logN++;
            slvLow = (sByteCnt != nakAt);
            goTx = (logN == 1 || logArr[logN-2] == 'h100) && sh[0] && slvLow;
            sByteCnt++;
          end else if (sBit == 9) begin
            sBit = 0; slvLow = 0;
            if (goTx) begin
              mode = 2; sh = rdBuf[rdIdx]; rdIdx++; slvLow = !sh[7]; goTx = 0;
            end
          end
        end else if (mode == 2) begin
          if (sBit == 9) begin
            sBit = 0;
            if (mAckd) begin sh = rdBuf[rdIdx]; rdIdx++; slvLow = !sh[7]; end
            else begin mode = 0; slvLow = 0; end
          end else if (sBit == 8) slvLow = 0;
          else if (sBit >= 1) slvLow = !sh[7-sBit];
        end
      end
      pScl = scl; pSda = sdaBus;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [1:0] op, input logic eia, input logic [2:0] size,
                                     input logic [9:0] addr, input logic [7:0] ia,
                                     input logic [31:0] data, input logic rd);
    return {1'b1, rd, op, eia, size, 6'b0, addr, ia, data};
  endfunction

  task automatic ex(input int v);
    expArr[expN] = v; expN++;
  endtask

  task automatic cmpLog(input string req);
    chk(req, 64'(logN), 64'(expN));
    for (int i = 0; i < expN && i < logN; i++) chk(req, 64'(logArr[i]), 64'(expArr[i]));
  endtask

  task automatic hostCmd(input logic [63:0] v);
    @(negedge clk); wrData = v; cmdWrEn = 1; @(negedge clk); cmdWrEn = 0;
  endtask

  task automatic hostExt(input logic [63:0] v);
    @(negedge clk); wrData = v; extWrEn = 1; @(negedge clk); extWrEn = 0;
  endtask

  task automatic pulseClr(input logic [1:0] v);
    @(negedge clk); intClr = v; @(negedge clk); intClr = 0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (cmdWord[63] && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk("R1 done timeout", 64'd1, 64'd0);
    repeat (6) @(negedge clk);
  endtask

  task automatic prep(input int nak);
    logN = 0; expN = 0; rdIdx = 0; ackN = 0; mAcks = 0; sByteCnt = 0; nakAt = nak;
    pulseClr(2'b11);
  endtask

  task automatic runTxn(input logic [63:0] c);
    hostCmd(c);
    @(negedge clk);
    chk("R1 go bit busy", 64'(cmdWord[63]), 64'd1);
    waitDone();
  endtask

  task automatic tReset();
    chk("R11 cmd reset", cmdWord, 64'd0);
    chk("R11 ext reset", extWord, 64'd0);
    chk("R11 irq reset", 64'(irq), 64'd0);
    chk("R11 lines free", 64'({sclLow, sdaLow}), 64'd0);
  endtask

  task automatic tWrite3();
    logic [63:0] c = mk(2'b00, 0, 3'd2, 10'h050, 8'h00, 32'h00A1B2C3, 0);
    prep(-1); runTxn(c);
    ex('h100); ex('hA0); ex('hA1); ex('hB2); ex('hC3); ex('h200);
    cmpLog("R2 R3 write3 bus bytes");
    chk("R1 R6 write3 result word", cmdWord, (c & ~(64'd1 << 63)) | (64'd1 << 62));
    chk("R8 irq after done", 64'(irq), 64'd1);
  endtask

  task automatic tIrqClear();
    pulseClr(2'b01);
    chk("R8 partial clear ignored", 64'(irq), 64'd1);
    pulseClr(2'b10);
    chk("R8 partial clear ignored 2", 64'(irq), 64'd1);
    pulseClr(2'b11);
    chk("R8 full clear", 64'(irq), 64'd0);
  endtask

  task automatic tWrite6();
    hostExt(64'h1122);
    prep(-1); runTxn(mk(2'b00, 0, 3'd5, 10'h050, 8'h00, 32'h33445566, 0));
    ex('h100); ex('hA0); ex('h11); ex('h22); ex('h33); ex('h44); ex('h55); ex('h66); ex('h200);
    cmpLog("R2 write6 lane order");
    chk("R6 write6 ok", 64'(cmdWord[62]), 64'd1);
  endtask

  task automatic tRead5();
    hostExt(64'h0);
    for (int i = 0; i < 5; i++) rdBuf[i] = 8'hD0 + 8'(i);
    prep(-1); runTxn(mk(2'b00, 0, 3'd4, 10'h050, 8'h00, 32'h0, 1));
    ex('h100); ex('hA1); ex('h200);
    cmpLog("R3 read5 header");
    chk("R5 read5 cmd lanes", 64'(cmdWord[31:0]), 64'hD1D2D3D4);
    chk("R5 read5 ext lane", 64'(extWord[7:0]), 64'hD0);
    chk("R7 read5 ack pattern", 64'(mAcks[4:0]), 64'b01111);
    chk("R6 read5 ok", 64'(cmdWord[62]), 64'd1);
  endtask

  task automatic tCompRead2IA();
    hostExt(64'h12 << 32);
    rdBuf[0] = 8'hE0; rdBuf[1] = 8'hE1;
    prep(-1); runTxn(mk(2'b01, 1, 3'd1, 10'h050, 8'h34, 32'h0, 1));
    ex('h100); ex('hA0); ex('h12); ex('h34); ex('h100); ex('hA1); ex('h200);
    cmpLog("R4 composite read two-byte index");
    chk("R5 composite read data", 64'(cmdWord[15:0]), 64'hE0E1);
    chk("R7 composite read acks", 64'(mAcks[1:0]), 64'b01);
  endtask

  task automatic tCompWrite();
    prep(-1); runTxn(mk(2'b01, 0, 3'd1, 10'h050, 8'h77, 32'h0000C0C1, 0));
    ex('h100); ex('hA0); ex('h77); ex('hC0); ex('hC1); ex('h200);
    cmpLog("R4 composite write one-byte index");
  endtask

  task automatic tTenWrite();
    prep(-1); runTxn(mk(2'b10, 0, 3'd0, 10'h2A5, 8'h00, 32'h5C, 0));
    ex('h100); ex('hF4); ex('hA5); ex('h5C); ex('h200);
    cmpLog("R3 ten-bit write");
  endtask

  task automatic tTenRead();
    rdBuf[0] = 8'h9E;
    prep(-1); runTxn(mk(2'b10, 0, 3'd0, 10'h2A5, 8'h00, 32'h0, 1));
    ex('h100); ex('hF4); ex('hA5); ex('h100); ex('hF5); ex('h200);
    cmpLog("R3 ten-bit read sequence");
    chk("R5 ten-bit read byte", 64'(cmdWord[7:0]), 64'h9E);
    chk("R7 single byte nak", 64'(mAcks[0]), 64'd0);
  endtask

  task automatic tAddrNak();
    prep(0); runTxn(mk(2'b00, 0, 3'd1, 10'h050, 8'h00, 32'hAABB, 0));
    ex('h100); ex('hA0); ex('h200);
    cmpLog("R6 address nak stops");
    chk("R6 address nak flag", 64'(cmdWord[62]), 64'd0);
    chk("R6 address nak status", 64'(cmdWord[7:0]), 64'h20);
    chk("R1 address nak go cleared", 64'(cmdWord[63]), 64'd0);
  endtask

  task automatic tDataNak();
    prep(2); runTxn(mk(2'b00, 0, 3'd3, 10'h050, 8'h00, 32'h01020304, 0));
    ex('h100); ex('hA0); ex('h01); ex('h02); ex('h200);
    cmpLog("R6 data nak stops early");
    chk("R6 data nak status", 64'(cmdWord[7:0]), 64'h30);
    chk("R6 data nak flag", 64'(cmdWord[62]), 64'd0);
  endtask

  task automatic tReadHdrNak();
    prep(0); runTxn(mk(2'b00, 0, 3'd0, 10'h050, 8'h00, 32'h0, 1));
    ex('h100); ex('hA1); ex('h200);
    cmpLog("R6 read header nak");
    chk("R6 read header nak status", 64'(cmdWord[7:0]), 64'h48);
  endtask

  task automatic tBusyIgnore();
    logic [63:0] c = mk(2'b00, 0, 3'd0, 10'h050, 8'h00, 32'h5A, 0);
    hostExt(64'h0);
    prep(-1); hostCmd(c);
    repeat (20) @(negedge clk);
    hostCmd(mk(2'b00, 0, 3'd3, 10'h033, 8'h00, 32'hFFFFFFFF, 0));
    hostExt(64'hFFFF);
    waitDone();
    ex('h100); ex('hA0); ex('h5A); ex('h200);
    cmpLog("R9 busy write did not alter bus");
    chk("R9 busy cmd write ignored", cmdWord, (c & ~(64'd1 << 63)) | (64'd1 << 62));
    chk("R9 busy ext write ignored", extWord, 64'd0);
  endtask

  task automatic tTiming();
    chk("R10 scl low pulses seen", 64'(pulses > 50), 64'd1);
    chk("R10 scl low width two ticks", 64'(badPulses), 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tWrite3();
    tIrqClear();
    tWrite6();
    tRead5();
    tCompRead2IA();
    tCompWrite();
    tTenWrite();
    tTenRead();
    tAddrNak();
    tDataNak();
    tReadHdrNak();
    tBusyIgnore();
    tTiming();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R1 watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule